// File: doc/BRIEF.md
# AXI4 Request Channel Stream Encapsulator

This block sits on the initiator side of a memory-mapped-over-stream link. It accepts the three AXI4 request channels (write address, read address and write data) on a slave-side interface, and it sends every accepted beat out on one AXI4-Stream master port. Each beat is flattened into a bit vector with its first field at bit 0. The vector is zero-extended at the top to a whole number of stream words. The words go out least-significant first, and a 3-bit stream ID tags each one with the channel it came from. A matching expander at the far end can rebuild the original channel beats from the ID and the end-of-vector marker.

Each request channel has a one-entry holding register. A channel is ready only while its register is empty. A serializer takes one held vector at a time and sends all of its words. It picks the next vector among the occupied registers in round-robin order. The widths of the ID, address, data and stream word are parameters. The defaults are a 4-bit ID, a 32-bit address, 32-bit data and a 2-byte stream word. At these defaults an address vector is 61 bits and takes 4 words, and a write-data vector is 37 bits and takes 3 words.

Top module: `req_stream_encap`

## Requirements
- R1: After reset, and for as long as reset is held, `st_valid` is low and all three request READY outputs are high.
- R2: The write-address vector is packed from bit 0 upward in this order: ID, ADDR, LEN (8 bits), SIZE (3), BURST (2), LOCK (1), CACHE (4), PROT (3), QOS (4). At the defaults the ID is bits 3:0, the address is bits 35:4 and QOS is bits 60:57.
- R3: The read-address vector uses the same layout as the write-address vector, field for field.
- R4: The write-data vector is packed from bit 0 upward as WDATA, then WSTRB, then WLAST. At the defaults these are bits 31:0, 35:32 and 36.
- R5: Every bit above the packed fields, up to the next multiple of the stream word width, is sent as zero.
- R6: A vector is sent as ceil(vector width / word width) stream words, with the least-significant word first. `st_last` is high on the final word only, and `st_keep` is all ones on every word.
- R7: `st_id` is 0 for write-address words, 1 for read-address words and 2 for write-data words.
- R8: A request channel READY is low while that channel's vector is held. A beat offered during that time is not taken, and it does not change the vector being sent.
- R9: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_data`, `st_id` and `st_last` stay unchanged.
- R10: The words of one vector are never interleaved with the words of another vector. Between vectors, the next channel is the first occupied one after the channel last picked, in the cyclic order 0, 1, 2. After reset the search starts at channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aclk | input | 1 | Clock; all signals are sampled on its rising edge |
| aresetn | input | 1 | Active-low reset, synchronous to aclk |
| req_aw_id | input | ID_W | Write-address ID |
| req_aw_addr | input | ADDR_W | Write address |
| req_aw_len | input | 8 | Write burst length |
| req_aw_size | input | 3 | Write beat size |
| req_aw_burst | input | 2 | Write burst type |
| req_aw_lock | input | 1 | Write lock type |
| req_aw_cache | input | 4 | Write memory attributes |
| req_aw_prot | input | 3 | Write protection type |
| req_aw_qos | input | 4 | Write quality-of-service |
| req_aw_valid | input | 1 | Write-address beat valid |
| req_aw_ready | output | 1 | Write-address holding register empty |
| req_ar_id | input | ID_W | Read-address ID |
| req_ar_addr | input | ADDR_W | Read address |
| req_ar_len | input | 8 | Read burst length |
| req_ar_size | input | 3 | Read beat size |
| req_ar_burst | input | 2 | Read burst type |
| req_ar_lock | input | 1 | Read lock type |
| req_ar_cache | input | 4 | Read memory attributes |
| req_ar_prot | input | 3 | Read protection type |
| req_ar_qos | input | 4 | Read quality-of-service |
| req_ar_valid | input | 1 | Read-address beat valid |
| req_ar_ready | output | 1 | Read-address holding register empty |
| req_w_data | input | DATA_W | Write data |
| req_w_strb | input | DATA_W/8 | Write byte strobes |
| req_w_last | input | 1 | Last write beat of a burst |
| req_w_valid | input | 1 | Write-data beat valid |
| req_w_ready | output | 1 | Write-data holding register empty |
| st_data | output | 8*TBYTES | Stream word |
| st_keep | output | TBYTES | Byte qualifiers, all ones |
| st_last | output | 1 | Final word of a vector |
| st_id | output | 3 | Source channel code |
| st_valid | output | 1 | Stream word valid |
| st_ready | input | 1 | Stream sink accepts the word |

## Verification
The checker assumes that the stream sink obeys the handshake. It also assumes that a channel VALID arrives only while the reset is released, and that the stream ID on a valid word stays within the three channel codes. Under these assumptions the beat counter in the checker can tie `st_last` to the expected word count. The bench always raises a VALID at a falling edge and keeps it high until it has seen READY there. It lowers it in the cycle after the handshake. Every back-pressure phase holds `st_ready` low for whole cycles.

// File: rtl/mm_req_pkg.sv
package mm_req_pkg;

    // Number of request channels that share the stream.
    localparam int NUM_SRC = 3;
    // Width of the stream routing tag.
    localparam int TID_W   = 3;
    // Address-channel control bits: LEN 8, SIZE 3, BURST 2, LOCK 1, CACHE 4, PROT 3, QOS 4.
    localparam int ACTRL_W = 8 + 3 + 2 + 1 + 4 + 3 + 4;

    // Channel codes carried on the stream tag; the expander decodes them.
    typedef enum logic [1:0] {
        SRC_WADDR = 2'd0,
        SRC_RADDR = 2'd1,
        SRC_WDATA = 2'd2
    } src_e;

    function automatic int div_up(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/req_slot.sv
// One-entry holding register for a flattened request beat.
module req_slot #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] in_vec,
    input  logic             take,
    output logic             full,
    output logic [VEC_W-1:0] vec
);

    typedef struct packed {
        logic             full;
        logic [VEC_W-1:0] vec;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (take) begin
            s_d.full = 1'b0;
        end
        if (in_valid && !s_q.full) begin
            s_d.full = 1'b1;
            s_d.vec  = in_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready = !s_q.full;
    assign full     = s_q.full;
    assign vec      = s_q.vec;

endmodule

// File: rtl/rr_pick.sv
// Round-robin selector: first requester after the last granted index.
module rr_pick #(
    parameter int N = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          load,
    output logic [IW-1:0] grant,
    output logic          any
);

    typedef struct packed {
        logic [IW-1:0] ptr;
    } rr_t;

    rr_t r_d, r_q;

    always_comb begin
        grant = r_q.ptr;
        any   = 1'b0;
        for (int k = 1; k <= N; k++) begin
            automatic int c = (int'(r_q.ptr) + k) % N;
            if (!any && req[c]) begin
                any   = 1'b1;
                grant = IW'(c);
            end
        end
    end

    always_comb begin
        r_d = r_q;
        if (load && any) begin
            r_d.ptr = grant;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ptr <= IW'(N - 1);
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/beat_sender.sv
// Locks onto one held vector and emits it word by word.
module beat_sender #(
    parameter int N  = 3,
    parameter int TW = 16,
    parameter int PW = 64,
    parameter int CW = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  full,
    input  logic [PW-1:0] vecs   [N],
    input  logic [CW-1:0] nbeats [N],
    output logic [N-1:0]  take,
    output logic [TW-1:0] o_data,
    output logic [IW-1:0] o_src,
    output logic          o_last,
    output logic          o_valid,
    input  logic          o_ready
);

    typedef struct packed {
        logic          active;
        logic [IW-1:0] ch;
        logic [CW-1:0] idx;
    } snd_t;

    snd_t s_d, s_q;

    logic [IW-1:0] pick_grant;
    logic          pick_any;
    logic          pick_load;
    logic          at_end;

    rr_pick #(.N(N)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (full),
        .load  (pick_load),
        .grant (pick_grant),
        .any   (pick_any)
    );

    assign at_end = (s_q.idx == nbeats[s_q.ch] - 1'b1);

    always_comb begin
        s_d       = s_q;
        take      = '0;
        pick_load = 1'b0;
        if (!s_q.active) begin
            if (pick_any) begin
                s_d.active = 1'b1;
                s_d.ch     = pick_grant;
                s_d.idx    = '0;
                pick_load  = 1'b1;
            end
        end else if (o_ready) begin
            if (at_end) begin
                s_d.active    = 1'b0;
                take[s_q.ch]  = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign o_valid = s_q.active;
    assign o_src   = s_q.ch;
    assign o_last  = s_q.active && at_end;
    assign o_data  = vecs[s_q.ch][int'(s_q.idx) * TW +: TW];

endmodule

// File: rtl/req_stream_encap.sv
module req_stream_encap
    import mm_req_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TBYTES = 2,
    localparam int STRB_W    = DATA_W / 8,
    localparam int TW        = 8 * TBYTES,
    localparam int A_VEC     = ID_W + ADDR_W + ACTRL_W,
    localparam int W_VEC     = DATA_W + STRB_W + 1,
    localparam int A_BEATS   = div_up(A_VEC, TW),
    localparam int W_BEATS   = div_up(W_VEC, TW),
    localparam int MAX_BEATS = max2(A_BEATS, W_BEATS),
    localparam int PW        = MAX_BEATS * TW,
    localparam int CW        = $clog2(MAX_BEATS + 1)
) (
    input  logic              aclk,
    input  logic              aresetn,
    input  logic [ID_W-1:0]   req_aw_id,
    input  logic [ADDR_W-1:0] req_aw_addr,
    input  logic [7:0]        req_aw_len,
    input  logic [2:0]        req_aw_size,
    input  logic [1:0]        req_aw_burst,
    input  logic              req_aw_lock,
    input  logic [3:0]        req_aw_cache,
    input  logic [2:0]        req_aw_prot,
    input  logic [3:0]        req_aw_qos,
    input  logic              req_aw_valid,
    output logic              req_aw_ready,
    input  logic [ID_W-1:0]   req_ar_id,
    input  logic [ADDR_W-1:0] req_ar_addr,
    input  logic [7:0]        req_ar_len,
    input  logic [2:0]        req_ar_size,
    input  logic [1:0]        req_ar_burst,
    input  logic              req_ar_lock,
    input  logic [3:0]        req_ar_cache,
    input  logic [2:0]        req_ar_prot,
    input  logic [3:0]        req_ar_qos,
    input  logic              req_ar_valid,
    output logic              req_ar_ready,
    input  logic [DATA_W-1:0] req_w_data,
    input  logic [STRB_W-1:0] req_w_strb,
    input  logic              req_w_last,
    input  logic              req_w_valid,
    output logic              req_w_ready,
    output logic [TW-1:0]     st_data,
    output logic [TBYTES-1:0] st_keep,
    output logic              st_last,
    output logic [TID_W-1:0]  st_id,
    input  logic              st_ready,
    output logic              st_valid
);

    localparam int IW = $clog2(NUM_SRC);

    // Address channels share one layout; index 0 = write, 1 = read.
    logic [A_VEC-1:0]   a_in    [2];
    logic [A_VEC-1:0]   a_held  [2];
    logic [1:0]         a_valid;
    logic [1:0]         a_ready;
    logic [W_VEC-1:0]   w_in;
    logic [W_VEC-1:0]   w_held;

    logic [NUM_SRC-1:0] full;
    logic [NUM_SRC-1:0] take;
    logic [PW-1:0]      vecs   [NUM_SRC];
    logic [CW-1:0]      nbeats [NUM_SRC];
    logic [IW-1:0]      src;

    assign a_in[0] = {req_aw_qos, req_aw_prot, req_aw_cache, req_aw_lock,
                      req_aw_burst, req_aw_size, req_aw_len, req_aw_addr, req_aw_id};
    assign a_in[1] = {req_ar_qos, req_ar_prot, req_ar_cache, req_ar_lock,
                      req_ar_burst, req_ar_size, req_ar_len, req_ar_addr, req_ar_id};
    assign a_valid = {req_ar_valid, req_aw_valid};
    assign w_in    = {req_w_last, req_w_strb, req_w_data};

    for (genvar g = 0; g < 2; g++) begin : g_aslot
        req_slot #(.VEC_W(A_VEC)) u_slot (
            .clk      (aclk),
            .rst_n    (aresetn),
            .in_valid (a_valid[g]),
            .in_ready (a_ready[g]),
            .in_vec   (a_in[g]),
            .take     (take[g]),
            .full     (full[g]),
            .vec      (a_held[g])
        );
        assign vecs[g]   = PW'(a_held[g]);
        assign nbeats[g] = CW'(A_BEATS);
    end

    req_slot #(.VEC_W(W_VEC)) u_wslot (
        .clk      (aclk),
        .rst_n    (aresetn),
        .in_valid (req_w_valid),
        .in_ready (req_w_ready),
        .in_vec   (w_in),
        .take     (take[SRC_WDATA]),
        .full     (full[SRC_WDATA]),
        .vec      (w_held)
    );
    assign vecs[SRC_WDATA]   = PW'(w_held);
    assign nbeats[SRC_WDATA] = CW'(W_BEATS);

    assign req_aw_ready = a_ready[SRC_WADDR];
    assign req_ar_ready = a_ready[SRC_RADDR];

    beat_sender #(
        .N  (NUM_SRC),
        .TW (TW),
        .PW (PW),
        .CW (CW)
    ) u_send (
        .clk     (aclk),
        .rst_n   (aresetn),
        .full    (full),
        .vecs    (vecs),
        .nbeats  (nbeats),
        .take    (take),
        .o_data  (st_data),
        .o_src   (src),
        .o_last  (st_last),
        .o_valid (st_valid),
        .o_ready (st_ready)
    );

    assign st_id   = TID_W'(src);
    assign st_keep = '1;

endmodule

// File: rtl/req_stream_encap_chk.sv
module req_stream_encap_chk #(
    parameter int TBYTES  = 2,
    parameter int A_BEATS = 4,
    parameter int W_BEATS = 3
) (
    input logic                aclk,
    input logic                aresetn,
    input logic                req_aw_valid,
    input logic                req_aw_ready,
    input logic                req_ar_valid,
    input logic                req_ar_ready,
    input logic                req_w_valid,
    input logic                req_w_ready,
    input logic [8*TBYTES-1:0] st_data,
    input logic [TBYTES-1:0]   st_keep,
    input logic                st_last,
    input logic [2:0]          st_id,
    input logic                st_valid,
    input logic                st_ready
);

    logic [15:0] cnt_q;
    int          exp_beats;

    assign exp_beats = (st_id == 3'd2) ? W_BEATS : A_BEATS;

    always_ff @(posedge aclk) begin
        if (!aresetn) begin
            cnt_q <= '0;
        end else if (st_valid && st_ready) begin
            cnt_q <= st_last ? '0 : cnt_q + 16'd1;
        end
    end

    assert_hold_R9: assert property (@(posedge aclk) disable iff (!aresetn)
        st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_id) && $stable(st_last));

    assert_aw_block_R8: assert property (@(posedge aclk) disable iff (!aresetn)
        req_aw_valid && req_aw_ready |=> !req_aw_ready);

    assert_ar_block_R8: assert property (@(posedge aclk) disable iff (!aresetn)
        req_ar_valid && req_ar_ready |=> !req_ar_ready);

    assert_w_block_R8: assert property (@(posedge aclk) disable iff (!aresetn)
        req_w_valid && req_w_ready |=> !req_w_ready);

    assert_keep_R6: assert property (@(posedge aclk) disable iff (!aresetn)
        st_valid |-> (st_keep == {TBYTES{1'b1}}));

    assert_last_R6: assert property (@(posedge aclk) disable iff (!aresetn)
        st_valid |-> (st_last == (int'(cnt_q) == exp_beats - 1)));

    assert_id_R7: assert property (@(posedge aclk) disable iff (!aresetn)
        st_valid |-> (st_id <= 3'd2));

    assert_lock_R10: assert property (@(posedge aclk) disable iff (!aresetn)
        st_valid && st_ready && !st_last |=> st_valid && $stable(st_id));

endmodule

bind req_stream_encap req_stream_encap_chk #(
    .TBYTES  (TBYTES),
    .A_BEATS (A_BEATS),
    .W_BEATS (W_BEATS)
) u_chk (.*);

// File: tb/tb_req_stream_encap.sv
module tb_req_stream_encap;

    logic        aclk = 1'b0;
    logic        aresetn = 1'b0;
    logic [3:0]  aw_id, ar_id;
    logic [31:0] aw_addr, ar_addr;
    logic [7:0]  aw_len, ar_len;
    logic [2:0]  aw_size, ar_size;
    logic [1:0]  aw_burst, ar_burst;
    logic        aw_lock, ar_lock;
    logic [3:0]  aw_cache, ar_cache;
    logic [2:0]  aw_prot, ar_prot;
    logic [3:0]  aw_qos, ar_qos;
    logic        aw_valid = 1'b0, ar_valid = 1'b0, w_valid = 1'b0;
    logic        aw_ready, ar_ready, w_ready;
    logic [31:0] w_data;
    logic [3:0]  w_strb;
    logic        w_last;
    logic [15:0] st_data;
    logic [1:0]  st_keep;
    logic        st_last;
    logic [2:0]  st_id;
    logic        st_valid;
    logic        st_ready = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 aclk = ~aclk;

    req_stream_encap dut (
        .aclk(aclk), .aresetn(aresetn),
        .req_aw_id(aw_id), .req_aw_addr(aw_addr), .req_aw_len(aw_len),
        .req_aw_size(aw_size), .req_aw_burst(aw_burst), .req_aw_lock(aw_lock),
        .req_aw_cache(aw_cache), .req_aw_prot(aw_prot), .req_aw_qos(aw_qos),
        .req_aw_valid(aw_valid), .req_aw_ready(aw_ready),
        .req_ar_id(ar_id), .req_ar_addr(ar_addr), .req_ar_len(ar_len),
        .req_ar_size(ar_size), .req_ar_burst(ar_burst), .req_ar_lock(ar_lock),
        .req_ar_cache(ar_cache), .req_ar_prot(ar_prot), .req_ar_qos(ar_qos),
        .req_ar_valid(ar_valid), .req_ar_ready(ar_ready),
        .req_w_data(w_data), .req_w_strb(w_strb), .req_w_last(w_last),
        .req_w_valid(w_valid), .req_w_ready(w_ready),
        .st_data(st_data), .st_keep(st_keep), .st_last(st_last), .st_id(st_id),
        .st_ready(st_ready), .st_valid(st_valid)
    );

    // {channel code, seed}
    localparam logic [33:0] VECS [8] = '{
        {2'd0, 32'h0000_0000}, {2'd1, 32'hFFFF_FFFF},
        {2'd2, 32'h1234_5678}, {2'd0, 32'hDEAD_BEEF},
        {2'd2, 32'hFFFF_FFFF}, {2'd1, 32'h0F0F_1E2D},
        {2'd2, 32'h8000_0001}, {2'd0, 32'h7654_3210}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Address vector per R2/R3: id, addr, len, size, burst, lock, cache, prot, qos, 3 pad bits.
    function automatic logic [63:0] addr_vec(input logic [31:0] s);
        return {3'b000, s[28:25], s[24:22], s[21:18], s[17], s[16:15], s[14:12],
                s[11:4], s ^ 32'hA5A5_0000, s[3:0]};
    endfunction

    // Write-data vector per R4: data, strb, last, 11 pad bits.
    function automatic logic [63:0] wdat_vec(input logic [31:0] s);
        return {16'h0000, 11'd0, s[31], s[3:0] ^ 4'hF, s};
    endfunction

    task automatic send(input int ch, input logic [31:0] s);
        @(negedge aclk);
        if (ch == 0) begin
            aw_id = s[3:0]; aw_addr = s ^ 32'hA5A5_0000; aw_len = s[11:4];
            aw_size = s[14:12]; aw_burst = s[16:15]; aw_lock = s[17];
            aw_cache = s[21:18]; aw_prot = s[24:22]; aw_qos = s[28:25];
            aw_valid = 1'b1;
            while (!aw_ready) @(negedge aclk);
            @(negedge aclk);
            aw_valid = 1'b0;
        end else if (ch == 1) begin
            ar_id = s[3:0]; ar_addr = s ^ 32'hA5A5_0000; ar_len = s[11:4];
            ar_size = s[14:12]; ar_burst = s[16:15]; ar_lock = s[17];
            ar_cache = s[21:18]; ar_prot = s[24:22]; ar_qos = s[28:25];
            ar_valid = 1'b1;
            while (!ar_ready) @(negedge aclk);
            @(negedge aclk);
            ar_valid = 1'b0;
        end else begin
            w_data = s; w_strb = s[3:0] ^ 4'hF; w_last = s[31];
            w_valid = 1'b1;
            while (!w_ready) @(negedge aclk);
            @(negedge aclk);
            w_valid = 1'b0;
        end
    endtask

    task automatic expect_vec(input int ch, input logic [31:0] s);
        logic [63:0] v;
        int nb;
        string dtag;
        v    = (ch == 2) ? wdat_vec(s) : addr_vec(s);
        nb   = (ch == 2) ? 3 : 4;
        dtag = (ch == 0) ? "R2" : (ch == 1) ? "R3" : "R4";
        for (int b = 0; b < nb; b++) begin
            while (!st_valid) @(negedge aclk);
            chk(st_data == v[b*16 +: 16], dtag, 64'(st_data), 64'(v[b*16 +: 16]));
            chk(st_id == 3'(ch), "R7 id", 64'(st_id), 64'(ch));
            chk(st_last == (b == nb - 1), "R6 last", 64'(st_last), 64'(b == nb - 1));
            chk(st_keep == 2'b11, "R6 keep", 64'(st_keep), 64'h3);
            if (b == nb - 1) begin
                if (ch == 2) chk(st_data[15:5] == 11'd0, "R5 pad", 64'(st_data[15:5]), 64'h0);
                else         chk(st_data[15:13] == 3'd0, "R5 pad", 64'(st_data[15:13]), 64'h0);
            end
            @(negedge aclk);
        end
    endtask

    initial begin
        #(8 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] held;
        repeat (4) @(negedge aclk);
        // R1: while reset is held
        chk(!st_valid && aw_ready && ar_ready && w_ready, "R1 in reset",
            {st_valid, aw_ready, ar_ready, w_ready}, 64'h7);
        aresetn = 1'b1;
        @(negedge aclk);
        chk(!st_valid && aw_ready && ar_ready && w_ready, "R1 after reset",
            {st_valid, aw_ready, ar_ready, w_ready}, 64'h7);

        // Table walk, sink always ready (R2 R3 R4 R5 R6 R7)
        st_ready = 1'b1;
        for (int i = 0; i < 8; i++) begin
            send(int'(VECS[i][33:32]), VECS[i][31:0]);
            expect_vec(int'(VECS[i][33:32]), VECS[i][31:0]);
        end

        // R10: last pick is read address, so with all three held the order is 2, 0, 1
        send(1, 32'h1357_9BDF);
        expect_vec(1, 32'h1357_9BDF);
        st_ready = 1'b0;
        fork
            send(0, 32'hAAAA_5555);
            send(1, 32'h5555_AAAA);
            send(2, 32'hC3C3_3C3C);
        join
        repeat (2) @(negedge aclk);
        st_ready = 1'b1;
        expect_vec(2, 32'hC3C3_3C3C);
        expect_vec(0, 32'hAAAA_5555);
        expect_vec(1, 32'h5555_AAAA);

        // R9: back-pressure holds the word; R8: a held channel refuses new beats
        st_ready = 1'b0;
        send(0, 32'h0BAD_F00D);
        while (!st_valid) @(negedge aclk);
        held = st_data;
        repeat (3) @(negedge aclk);
        chk(st_valid && st_data == held && st_id == 3'd0, "R9 hold",
            {st_valid, st_id, st_data}, {1'b1, 3'd0, held});
        chk(!aw_ready, "R8 ready low", 64'(aw_ready), 64'h0);
        st_ready = 1'b1;
        fork
            send(0, 32'h600D_CAFE);
            expect_vec(0, 32'h0BAD_F00D);
        join
        expect_vec(0, 32'h600D_CAFE);

        // R1: reset in the middle of a held vector
        st_ready = 1'b0;
        send(2, 32'h2468_ACE0);
        repeat (2) @(negedge aclk);
        aresetn = 1'b0;
        repeat (2) @(negedge aclk);
        chk(!st_valid && aw_ready && ar_ready && w_ready, "R1 mid reset",
            {st_valid, aw_ready, ar_ready, w_ready}, 64'h7);
        aresetn = 1'b1;
        repeat (3) @(negedge aclk);
        chk(!st_valid, "R1 cleared slot", 64'(st_valid), 64'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule